// File: doc/BRIEF.md
# Speculative Indirect-Branch Path History

This block keeps the ordered list of indirect branches seen by one thread, from the moment each is predicted until well after it retires. Every entry carries the branch address, the target it was steered to and a 16-bit sequence tag. The front end records each predicted indirect branch at the young end. The back end commits by sequence tag, removes wrong-path branches by sequence tag, and repairs the target of the newest entry after a misprediction.

The block drives a short vector of the most recent targets, newest first, with a valid bit per slot. A target-cache index hash consumes this vector. A few committed targets are held back from retirement, so the hash keeps its path context once the in-flight branches have drained. A `skip_newest` input drops the youngest entry from the vector, which is the view a repair hash needs. `young_pc` gives that youngest branch's address, for the same purpose.

Storage is a circular buffer. A full flag tells the front end that further records will be lost. A sticky overflow bit records that a record was lost.

Top module: `ind_path_hist`

## Requirements
- R1: After a synchronous reset the history is empty: `path_vld`, `young_vld`, `full` and `overflow` are all 0.
- R2: A record appends an entry at the young end. `path_tgt` slot 0 (bits PC_W-1:0) shows the newest target and slot 1 the next older one, up to PATH_LEN slots. The valid bit of a slot is set only when an entry exists for it.
- R3: When DEPTH entries are held, `full` is 1 and a record is dropped without changing any output except `overflow`. `overflow` becomes 1 and stays 1 until reset.
- R4: A squash with tag S removes every entry whose tag is later than S. Entries at or before S are left unchanged.
- R5: A commit while the history is empty has no effect, not even on the committed-entry count.
- R6: A commit whose tag is at or after the tag of the oldest uncommitted entry marks that entry committed, while fewer than PATH_LEN entries are committed. Once PATH_LEN are committed, it retires the oldest entry instead. Each request advances by at most one entry.
- R7: A commit whose tag is earlier than the tag of the oldest uncommitted entry has no effect.
- R8: A repair replaces the target of the newest entry with `fix_tgt`.
- R9: With `skip_newest` at 1, the vector starts at the second-newest entry. `young_pc` always shows the address of the newest entry, qualified by `young_vld`.
- R10: Only one request is served per cycle. Squash wins over commit, commit wins over record, and record wins over repair. A request that loses is dropped.
- R11: Tags are compared by wrap-around arithmetic. A is later than B when the 16-bit difference A-B, read as a signed number, is positive.
- R12: Outputs are registered. They show the history as it was after the previous clock edge, so each update appears at the outputs one cycle after the edge that applied it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Record a predicted indirect branch |
| rec_pc | input | PC_W | Branch address to record |
| rec_tgt | input | PC_W | Predicted or fall-through target to record |
| rec_seq | input | SEQ_W | Sequence tag of the recorded branch |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Newest retired sequence tag |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Last surviving sequence tag |
| fix_valid | input | 1 | Repair the newest entry's target |
| fix_tgt | input | PC_W | Corrected target |
| skip_newest | input | 1 | Leave the newest entry out of the vector |
| path_tgt | output | PATH_LEN*PC_W | Recent targets, slot 0 newest |
| path_vld | output | PATH_LEN | Valid bit per slot |
| young_pc | output | PC_W | Address of the newest entry |
| young_vld | output | 1 | History not empty |
| full | output | 1 | Buffer holds DEPTH entries |
| overflow | output | 1 | Sticky: a record was dropped |

## Verification
On every cycle the assertions check the bookkeeping invariants. The occupancy never exceeds the depth and the committed count never exceeds its limit or the occupancy. A squash never grows the history, and a commit changes occupancy by at most one. An empty commit leaves all state alone, overflow stays sticky, the slot valid bits are contiguous from slot 0, and `full` follows the occupancy with one cycle of lag. Only the directed scenarios can show which targets appear in which slot. They also show that wrap-around tags squash the right entries and that the committed-context window delays retirement by exactly PATH_LEN commits. Finally, they show which request wins when several arrive together.

// File: rtl/ind_path_pkg.sv
package ind_path_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_SQUASH,
    OP_COMMIT,
    OP_RECORD,
    OP_REPAIR
  } hist_op_e;

  // Fixed priority: squash, commit, record, repair.
  function automatic hist_op_e pick_op(input logic sq, input logic cm,
                                       input logic rc, input logic fx);
    if (sq)      return OP_SQUASH;
    else if (cm) return OP_COMMIT;
    else if (rc) return OP_RECORD;
    else if (fx) return OP_REPAIR;
    else         return OP_IDLE;
  endfunction

endpackage

// File: rtl/ind_path_scan.sv
// Counts how many held entries survive a squash (tag not later than lim).
module ind_path_scan #(
  parameter int DEPTH = 16,
  parameter int SEQ_W = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_tab,
  input  logic [PTR_W-1:0]            head,
  input  logic [CNT_W-1:0]            cnt,
  input  logic [SEQ_W-1:0]            lim,
  output logic [CNT_W-1:0]            keep
);

  logic [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [PTR_W-1:0] phys;
    logic [SEQ_W-1:0] diff;
    assign phys   = head + PTR_W'(i);
    assign diff   = seq_tab[phys] - lim;
    assign hit[i] = (CNT_W'(i) < cnt) && (diff[SEQ_W-1] || (diff == '0));
  end

  always_comb begin
    keep = '0;
    for (int i = 0; i < DEPTH; i++) begin
      keep = keep + {{(CNT_W-1){1'b0}}, hit[i]};
    end
  end

endmodule

// File: rtl/ind_path_pc_ram.sv
// Simple dual-port memory with synchronous read, shaped for block RAM.
module ind_path_pc_ram #(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [PC_W-1:0]  wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [PC_W-1:0]  rdata
);

  logic [PC_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/ind_path_sel.sv
// Registered selection of the newest targets, newest first.
module ind_path_sel #(
  parameter int DEPTH    = 16,
  parameter int PC_W     = 32,
  parameter int PATH_LEN = 3,
  parameter int PTR_W    = 4,
  parameter int CNT_W    = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [DEPTH-1:0][PC_W-1:0] tgt_tab,
  input  logic [PTR_W-1:0]           head,
  input  logic [CNT_W-1:0]           cnt,
  input  logic                       skip,
  output logic [PATH_LEN*PC_W-1:0]   path_tgt,
  output logic [PATH_LEN-1:0]        path_vld
);

  for (genvar p = 0; p < PATH_LEN; p++) begin : g_path
    logic             have;
    logic [PTR_W-1:0] phys;
    always_comb begin
      have = int'(cnt) > (p + int'(skip));
      phys = PTR_W'(int'(head) + int'(cnt) - 1 - p - int'(skip));
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        path_vld[p]             <= 1'b0;
        path_tgt[p*PC_W +: PC_W] <= '0;
      end else begin
        path_vld[p]             <= have;
        path_tgt[p*PC_W +: PC_W] <= have ? tgt_tab[phys] : '0;
      end
    end
  end

endmodule

// File: rtl/ind_path_hist.sv
module ind_path_hist
  import ind_path_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int SEQ_W    = 16,
  parameter int DEPTH    = 16,
  parameter int PATH_LEN = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rec_valid,
  input  logic [PC_W-1:0]          rec_pc,
  input  logic [PC_W-1:0]          rec_tgt,
  input  logic [SEQ_W-1:0]         rec_seq,
  input  logic                     cmt_valid,
  input  logic [SEQ_W-1:0]         cmt_seq,
  input  logic                     sq_valid,
  input  logic [SEQ_W-1:0]         sq_seq,
  input  logic                     fix_valid,
  input  logic [PC_W-1:0]          fix_tgt,
  input  logic                     skip_newest,
  output logic [PATH_LEN*PC_W-1:0] path_tgt,
  output logic [PATH_LEN-1:0]      path_vld,
  output logic [PC_W-1:0]          young_pc,
  output logic                     young_vld,
  output logic                     full,
  output logic                     overflow
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HP_W  = $clog2(PATH_LEN + 1);

  logic [PTR_W-1:0]            head_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [HP_W-1:0]             hptr_q;
  logic                        ovf_q;
  logic                        full_q;
  logic                        yvld_q;
  logic [DEPTH-1:0][SEQ_W-1:0] seq_tab;
  logic [DEPTH-1:0][PC_W-1:0]  tgt_tab;

  hist_op_e         op;
  logic [CNT_W-1:0] keep;
  logic             at_cap;
  logic [PTR_W-1:0] tail_idx;
  logic [PTR_W-1:0] new_idx;
  logic [PTR_W-1:0] cmt_idx;
  logic [SEQ_W-1:0] cmt_diff;
  logic             cmt_hit;
  logic             wr_rec;

  always_comb begin
    op       = pick_op(sq_valid, cmt_valid, rec_valid, fix_valid);
    at_cap   = (cnt_q == CNT_W'(DEPTH));
    tail_idx = head_q + PTR_W'(cnt_q);
    new_idx  = tail_idx - PTR_W'(1);
    cmt_idx  = head_q + PTR_W'(hptr_q);
    cmt_diff = seq_tab[cmt_idx] - cmt_seq;
    cmt_hit  = (cnt_q != '0) && (CNT_W'(hptr_q) < cnt_q)
               && (cmt_diff[SEQ_W-1] || (cmt_diff == '0));
    wr_rec   = (op == OP_RECORD) && !at_cap;
  end

  ind_path_scan #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_scan (
    .seq_tab(seq_tab), .head(head_q), .cnt(cnt_q), .lim(sq_seq), .keep(keep)
  );

  // Control state.
  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      cnt_q  <= '0;
      hptr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      unique case (op)
        OP_SQUASH: begin
          cnt_q <= keep;
          if (CNT_W'(hptr_q) > keep) hptr_q <= HP_W'(keep);
        end
        OP_COMMIT: begin
          if (cmt_hit) begin
            if (hptr_q >= HP_W'(PATH_LEN)) begin
              head_q <= head_q + PTR_W'(1);
              cnt_q  <= cnt_q - CNT_W'(1);
            end else begin
              hptr_q <= hptr_q + HP_W'(1);
            end
          end
        end
        OP_RECORD: begin
          if (at_cap) ovf_q <= 1'b1;
          else        cnt_q <= cnt_q + CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  // Entry tables (no reset; guarded by occupancy).
  always_ff @(posedge clk) begin
    if (wr_rec) begin
      seq_tab[tail_idx] <= rec_seq;
      tgt_tab[tail_idx] <= rec_tgt;
    end else if (op == OP_REPAIR && cnt_q != '0) begin
      tgt_tab[new_idx] <= fix_tgt;
    end
  end

  ind_path_pc_ram #(
    .DEPTH(DEPTH), .PC_W(PC_W), .PTR_W(PTR_W)
  ) u_pc_ram (
    .clk(clk), .we(wr_rec), .waddr(tail_idx), .wdata(rec_pc),
    .raddr(new_idx), .rdata(young_pc)
  );

  ind_path_sel #(
    .DEPTH(DEPTH), .PC_W(PC_W), .PATH_LEN(PATH_LEN), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_sel (
    .clk(clk), .rst(rst), .tgt_tab(tgt_tab), .head(head_q), .cnt(cnt_q),
    .skip(skip_newest), .path_tgt(path_tgt), .path_vld(path_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      yvld_q <= 1'b0;
    end else begin
      full_q <= at_cap;
      yvld_q <= (cnt_q != '0);
    end
  end

  assign full      = full_q;
  assign young_vld = yvld_q;
  assign overflow  = ovf_q;

endmodule

// File: rtl/ind_path_hist_chk.sv
module ind_path_hist_chk #(
  parameter int DEPTH    = 16,
  parameter int PATH_LEN = 3,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int HP_W    = $clog2(PATH_LEN + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                rec_valid,
  input logic                cmt_valid,
  input logic                sq_valid,
  input logic [CNT_W-1:0]    cnt,
  input logic [HP_W-1:0]     hptr,
  input logic                overflow,
  input logic                full,
  input logic [PATH_LEN-1:0] path_vld
);

  a_r3_cap_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r6_hptr_bound: assert property (@(posedge clk) disable iff (rst)
    (hptr <= HP_W'(PATH_LEN)) && (CNT_W'(hptr) <= cnt));

  a_r4_squash_shrinks: assert property (@(posedge clk) disable iff (rst)
    sq_valid |=> cnt <= $past(cnt));

  a_r6_one_step: assert property (@(posedge clk) disable iff (rst)
    (cmt_valid && !sq_valid) |=>
      (cnt == $past(cnt)) || (cnt == $past(cnt) - CNT_W'(1)));

  a_r5_empty_commit: assert property (@(posedge clk) disable iff (rst)
    (cmt_valid && !sq_valid && cnt == '0) |=> (cnt == '0) && $stable(hptr));

  a_r2_record_grows: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !sq_valid && !cmt_valid && cnt < CNT_W'(DEPTH)) |=>
      cnt == $past(cnt) + CNT_W'(1));

  a_r2_vld_contig: assert property (@(posedge clk) disable iff (rst)
    ((path_vld + PATH_LEN'(1)) & path_vld) == '0);

  a_r12_full_lag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> full == ($past(cnt) == CNT_W'(DEPTH)));

endmodule

bind ind_path_hist ind_path_hist_chk #(
  .DEPTH(DEPTH), .PATH_LEN(PATH_LEN)
) u_chk (
  .clk(clk), .rst(rst), .rec_valid(rec_valid), .cmt_valid(cmt_valid),
  .sq_valid(sq_valid), .cnt(cnt_q), .hptr(hptr_q), .overflow(overflow),
  .full(full), .path_vld(path_vld)
);

// File: tb/ind_path_hist_tb.sv
`timescale 1ns/1ps
module ind_path_hist_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        rec_valid, cmt_valid, sq_valid, fix_valid, skip_newest;
  logic [31:0] rec_pc, rec_tgt, fix_tgt;
  logic [15:0] rec_seq, cmt_seq, sq_seq;
  logic [95:0] path_tgt;
  logic [2:0]  path_vld;
  logic [31:0] young_pc;
  logic        young_vld, full, overflow;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ind_path_hist u_dut (
    .clk(clk), .rst(rst),
    .rec_valid(rec_valid), .rec_pc(rec_pc), .rec_tgt(rec_tgt), .rec_seq(rec_seq),
    .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
    .sq_valid(sq_valid), .sq_seq(sq_seq),
    .fix_valid(fix_valid), .fix_tgt(fix_tgt), .skip_newest(skip_newest),
    .path_tgt(path_tgt), .path_vld(path_vld), .young_pc(young_pc),
    .young_vld(young_vld), .full(full), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_path(input string req, input logic [2:0] vld,
                          input logic [31:0] t0, input logic [31:0] t1, input logic [31:0] t2);
    chk({req, " vld"}, 32'(path_vld), 32'(vld));
    if (vld[0]) chk({req, " slot0"}, path_tgt[31:0], t0);
    if (vld[1]) chk({req, " slot1"}, path_tgt[63:32], t1);
    if (vld[2]) chk({req, " slot2"}, path_tgt[95:64], t2);
  endtask

  task automatic idle_inputs();
    rec_valid = 0; cmt_valid = 0; sq_valid = 0; fix_valid = 0;
  endtask

  // Drive one request for one edge; returns at the negedge after that edge.
  task automatic do_op(input logic rc, input logic [31:0] pc, input logic [31:0] tg,
                       input logic [15:0] rs, input logic cm, input logic [15:0] cs,
                       input logic sq, input logic [15:0] ss,
                       input logic fx, input logic [31:0] ft);
    @(negedge clk);
    rec_valid = rc; rec_pc = pc; rec_tgt = tg; rec_seq = rs;
    cmt_valid = cm; cmt_seq = cs; sq_valid = sq; sq_seq = ss;
    fix_valid = fx; fix_tgt = ft;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic rec(input logic [31:0] pc, input logic [31:0] tg, input logic [15:0] s);
    do_op(1, pc, tg, s, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic cmt(input logic [15:0] s);
    do_op(0, 0, 0, 0, 1, s, 0, 0, 0, 0);
  endtask
  task automatic sqsh(input logic [15:0] s);
    do_op(0, 0, 0, 0, 0, 0, 1, s, 0, 0);
  endtask
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; idle_inputs(); skip_newest = 0;
    rec_pc = 0; rec_tgt = 0; rec_seq = 0; cmt_seq = 0; sq_seq = 0; fix_tgt = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    settle();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 path_vld", 32'(path_vld), 0);
    chk("R1 young_vld", 32'(young_vld), 0);
    chk("R1 full", 32'(full), 0);
    chk("R1 overflow", 32'(overflow), 0);
  endtask

  task automatic t_record_and_view();
    do_reset();
    rec(32'h100, 32'hA0, 16'd1);
    chk("R12 not yet visible", 32'(path_vld), 0);
    settle();
    chk_path("R2 one entry", 3'b001, 32'hA0, 0, 0);
    rec(32'h104, 32'hA4, 16'd2);
    rec(32'h108, 32'hA8, 16'd3);
    rec(32'h10C, 32'hAC, 16'd4);
    settle();
    chk_path("R2 newest first", 3'b111, 32'hAC, 32'hA8, 32'hA4);
    chk("R9 young_pc", young_pc, 32'h10C);
    chk("R9 young_vld", 32'(young_vld), 1);
    @(negedge clk); skip_newest = 1;
    settle();
    chk_path("R9 skip newest", 3'b111, 32'hA8, 32'hA4, 32'hA0);
    @(negedge clk); skip_newest = 0;
    settle();
  endtask

  task automatic t_squash_repair();
    // Continues from t_record_and_view: tags 1..4 held.
    sqsh(16'd2);
    settle();
    chk_path("R4 squash younger", 3'b011, 32'hA4, 32'hA0, 0);
    chk("R4 young_pc after squash", young_pc, 32'h104);
    do_op(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hF0);
    settle();
    chk_path("R8 repair newest", 3'b011, 32'hF0, 32'hA0, 0);
  endtask

  task automatic t_full_commit();
    do_reset();
    cmt(16'd100);
    for (int i = 0; i < 16; i++) rec(32'h200 + 32'(i*4), 32'h1000 + 32'(i), 16'(10 + i));
    settle();
    chk("R3 full", 32'(full), 1);
    chk("R3 no overflow yet", 32'(overflow), 0);
    rec(32'h999, 32'hDEAD, 16'd26);
    settle();
    chk("R3 overflow set", 32'(overflow), 1);
    chk_path("R3 dropped record", 3'b111, 32'h100F, 32'h100E, 32'h100D);
    for (int i = 0; i < 3; i++) cmt(16'd25);
    settle();
    chk("R5 R6 context kept, still full", 32'(full), 1);
    cmt(16'd25);
    settle();
    chk("R6 oldest retired", 32'(full), 0);
    chk_path("R6 newest intact", 3'b111, 32'h100F, 32'h100E, 32'h100D);
    rec(32'h300, 32'h2000, 16'd26);
    settle();
    chk_path("R2 record after retire", 3'b111, 32'h2000, 32'h100F, 32'h100E);
    chk("R3 overflow sticky", 32'(overflow), 1);
  endtask

  task automatic t_old_commit();
    do_reset();
    for (int i = 0; i < 16; i++) rec(32'h400, 32'h3000 + 32'(i), 16'(50 + i));
    for (int i = 0; i < 4; i++) cmt(16'd49);
    settle();
    chk("R7 early tag ignored", 32'(full), 1);
    for (int i = 0; i < 4; i++) cmt(16'd65);
    settle();
    chk("R6 retire after window", 32'(full), 0);
  endtask

  task automatic t_wrap();
    do_reset();
    rec(32'h500, 32'hC0, 16'hFFFE);
    rec(32'h504, 32'hC1, 16'hFFFF);
    rec(32'h508, 32'hC2, 16'h0000);
    rec(32'h50C, 32'hC3, 16'h0001);
    sqsh(16'hFFFF);
    settle();
    chk_path("R11 wrap squash", 3'b011, 32'hC1, 32'hC0, 0);
  endtask

  task automatic t_priority();
    do_reset();
    rec(32'h600, 32'hD0, 16'd1);
    rec(32'h604, 32'hD1, 16'd2);
    rec(32'h608, 32'hD2, 16'd3);
    do_op(1, 32'h60C, 32'hE0, 16'd9, 1, 16'd3, 1, 16'd1, 1, 32'hFF);
    settle();
    chk_path("R10 squash wins", 3'b001, 32'hD0, 0, 0);
    do_op(1, 32'h610, 32'hE9, 16'd9, 1, 16'd0, 0, 0, 0, 0);
    settle();
    chk_path("R10 commit beats record", 3'b001, 32'hD0, 0, 0);
    do_op(1, 32'h614, 32'hE1, 16'd10, 0, 0, 0, 0, 1, 32'hF9);
    settle();
    chk_path("R10 record beats repair", 3'b011, 32'hE1, 32'hD0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1; idle_inputs(); skip_newest = 0;
    t_reset();
    t_record_and_view();
    t_squash_repair();
    t_full_commit();
    t_old_commit();
    t_wrap();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule